// File: doc/BRIEF.md
# Multiplexed ROM Burst Reader

This block is a synchronous host-side controller for a sequential-access mask ROM whose address and data share one 16-bit bus. A single request carries a 22-bit word address and a word count. The controller then drives the whole exchange with the memory. It selects the chip and sends the upper address bits with their own latch strobe, then the lower address bits with a second latch strobe. It releases the bus, waits out the long first-access latency, and then pulses the read strobe once per word at the memory's minimum cycle time.

Every phase length is a whole number of system clocks, rounded up from nanosecond parameters and a clock-period parameter. Each returned word appears on `word_data` with a one-cycle `word_valid` pulse. The memory's internal word pointer wraps inside a 256-word page, so when a burst reaches a page boundary the controller sends a fresh address pair before it continues. A burst can run across page boundaries and across the top of the address space.

Top module: `mrom_burst_rd`

## Requirements
- R1: While reset is held and afterwards until a request is accepted, `rom_sel_n` and `rom_strobe_n` are 1, and `rom_lat_hi`, `rom_lat_lo`, `rom_ad_oe`, `busy` and `word_valid` are 0.
- R2: The upper address phase drives `{9'b0, addr[21:15]}` on `rom_ad_o`. The lower phase drives `{addr[14:0], 1'b0}`, so bit 0 of the lower word is unused and bits 8:1 carry the word within the page.
- R3: For every new address, the `rom_lat_hi` pulse falls before `rom_lat_lo` rises, the two latch strobes are never high together, and `rom_sel_n` is low for the whole sequence.
- R4: `rom_lat_hi` stays high for ceil(max(T_AS,T_CES)/CLK) clocks and `rom_lat_lo` for ceil(max(T_ALES,T_AS)/CLK) clocks. They are separated by ceil(T_ALED/CLK) clocks. The driven address word is stable and enabled throughout each latch pulse.
- R5: The first read strobe after a lower-address latch falls exactly ceil(T_LAT/CLK) clocks after that latch falls. `rom_ad_oe` is 0 whenever `rom_strobe_n` is low.
- R6: Each read strobe is low for ceil(T_ACC/CLK) clocks. Within a page it stays high for max(ceil(T_RDH/CLK), ceil(T_CYC/CLK) − low count) clocks, so strobe falls are at least T_CYC apart.
- R7: Each word is sampled from `rom_ad_i` on the edge that ends its strobe-low period. It is presented with a single-cycle `word_valid`, and exactly `req_len` words come back for consecutive addresses.
- R8: When the next word of a burst starts a new page, including the wrap from the last address to address 0, a complete upper/lower address sequence and a new latency wait come before its strobe.
- R9: A request with `req_len` of 0 is ignored, and so is a request made while `busy` is 1. In both cases no latch or strobe pulse occurs and no word is returned.
- R10: After the last word's strobe-high period, the controller returns to idle with `rom_sel_n` high and `busy` low. A burst that ends on the last word of a page does not re-address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, taken when idle |
| req_addr | input | 22 | First word address of the burst |
| req_len | input | 8 | Number of words to read |
| busy | output | 1 | A burst is in progress |
| word_data | output | 16 | Returned data word |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| rom_sel_n | output | 1 | Memory select, active low |
| rom_lat_hi | output | 1 | Latch strobe for the upper address word |
| rom_lat_lo | output | 1 | Latch strobe for the lower address word |
| rom_strobe_n | output | 1 | Read strobe, active low |
| rom_ad_oe | output | 1 | Output enable for `rom_ad_o` on the shared bus |
| rom_ad_o | output | 16 | Address word driven onto the shared bus |
| rom_ad_i | input | 16 | Data word read from the shared bus |

## Verification
Two decisions can fall on the same clock edge. One is the end of the strobe-high period after the word that closes a page. The other is the completion of the burst, and each would send the controller somewhere different. A burst is started so that its last word is the last word of a page, and the check requires one address pair only and a direct return to idle. Bursts that run across a page boundary and across the top of the address space check the other outcome. A second request is also raised during the last word's valid pulse, while `busy` is still high, and the check requires that no latch pulse and no extra word follow.

// File: rtl/mrom_pkg.sv
`timescale 1ns/1ps
package mrom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HI, ST_GAP, ST_LO, ST_WAIT, ST_STRB, ST_REST
  } mrom_st_e;

  // Whole clocks needed to cover t_ns, never less than one.
  function automatic int unsigned ns_to_clk(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned n;
    n = (t_ns + clk_ns - 1) / clk_ns;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Strobe-high clocks: the remainder of the cycle time, but at least the high minimum.
  function automatic int unsigned rest_clk(input int unsigned cyc, input int unsigned low,
                                           input int unsigned high_min);
    return (cyc > low) ? max_u(cyc - low, high_min) : high_min;
  endfunction

endpackage

// File: rtl/mrom_tick_ctr.sv
`timescale 1ns/1ps
module mrom_tick_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  // A phase loaded with n-1 lasts n cycles; expired marks its last one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/mrom_addr_gen.sv
`timescale 1ns/1ps
module mrom_addr_gen #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [DATA_W-1:0] hi_word,
  output logic [DATA_W-1:0] lo_word,
  output logic              page_start
);
  localparam int LO_BITS = DATA_W - 1;
  localparam int HI_BITS = ADDR_W - LO_BITS;

  logic [ADDR_W-1:0] addr_q;

  function automatic logic [DATA_W-1:0] mk_hi(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    w = '0;
    w[HI_BITS-1:0] = a[ADDR_W-1:LO_BITS];
    return w;
  endfunction

  // Bit 0 of the lower word is a byte select the memory ignores.
  function automatic logic [DATA_W-1:0] mk_lo(input logic [ADDR_W-1:0] a);
    return {a[LO_BITS-1:0], 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (load)  addr_q <= load_addr;
    else if (step)  addr_q <= addr_q + 1'b1;
  end

  assign hi_word    = mk_hi(addr_q);
  assign lo_word    = mk_lo(addr_q);
  assign page_start = (addr_q[PAGE_W-1:0] == '0);
endmodule

// File: rtl/mrom_burst_rd.sv
`timescale 1ns/1ps
module mrom_burst_rd
  import mrom_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int PAGE_W    = 8,
  parameter int LEN_W     = 8,
  parameter int CLK_NS    = 5,
  parameter int T_AS_NS   = 30,
  parameter int T_CES_NS  = 50,
  parameter int T_ALES_NS = 70,
  parameter int T_ALED_NS = 70,
  parameter int T_LAT_NS  = 950,
  parameter int T_CYC_NS  = 200,
  parameter int T_ACC_NS  = 150,
  parameter int T_RDH_NS  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic [DATA_W-1:0] word_data,
  output logic              word_valid,
  output logic              rom_sel_n,
  output logic              rom_lat_hi,
  output logic              rom_lat_lo,
  output logic              rom_strobe_n,
  output logic              rom_ad_oe,
  output logic [DATA_W-1:0] rom_ad_o,
  input  logic [DATA_W-1:0] rom_ad_i
);
  localparam int unsigned N_HI   = ns_to_clk(max_u(T_AS_NS, T_CES_NS), CLK_NS);
  localparam int unsigned N_GAP  = ns_to_clk(T_ALED_NS, CLK_NS);
  localparam int unsigned N_LO   = ns_to_clk(max_u(T_ALES_NS, T_AS_NS), CLK_NS);
  localparam int unsigned N_WAIT = ns_to_clk(T_LAT_NS, CLK_NS);
  localparam int unsigned N_STRB = ns_to_clk(T_ACC_NS, CLK_NS);
  localparam int unsigned N_REST = rest_clk(ns_to_clk(T_CYC_NS, CLK_NS), N_STRB,
                                            ns_to_clk(T_RDH_NS, CLK_NS));
  localparam int unsigned N_MAX  = max_u(max_u(max_u(N_HI, N_GAP), max_u(N_LO, N_WAIT)),
                                         max_u(N_STRB, N_REST));
  localparam int CNT_W = $clog2(N_MAX + 1);
  localparam logic [CNT_W-1:0] L_HI   = CNT_W'(N_HI - 1);
  localparam logic [CNT_W-1:0] L_GAP  = CNT_W'(N_GAP - 1);
  localparam logic [CNT_W-1:0] L_LO   = CNT_W'(N_LO - 1);
  localparam logic [CNT_W-1:0] L_WAIT = CNT_W'(N_WAIT - 1);
  localparam logic [CNT_W-1:0] L_STRB = CNT_W'(N_STRB - 1);
  localparam logic [CNT_W-1:0] L_REST = CNT_W'(N_REST - 1);
  localparam int unsigned P_CYC = N_STRB + N_REST;
  localparam int SINCE_W = $clog2(P_CYC + 1) + 1;

  mrom_st_e          st_q, st_d;
  logic [LEN_W-1:0]  rem_q;
  logic              ctr_load;
  logic [CNT_W-1:0]  ctr_val;
  logic              phase_done;
  logic [DATA_W-1:0] hi_word, lo_word;
  logic              page_start;

  // Named events used by the logic and the assertions.
  wire accept  = req_valid && (st_q == ST_IDLE) && (req_len != '0);
  wire sample  = (st_q == ST_STRB) && phase_done;
  wire rest_end = (st_q == ST_REST) && phase_done;
  wire finish  = rest_end && (rem_q == '0);
  wire readdr  = rest_end && (rem_q != '0) && page_start;

  mrom_tick_ctr #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(ctr_val), .expired(phase_done)
  );

  mrom_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_addr(req_addr), .step(sample),
    .hi_word(hi_word), .lo_word(lo_word), .page_start(page_start)
  );

  always_comb begin
    st_d     = st_q;
    ctr_load = 1'b0;
    ctr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (accept)     begin st_d = ST_HI;   ctr_load = 1'b1; ctr_val = L_HI;   end
      ST_HI:   if (phase_done) begin st_d = ST_GAP;  ctr_load = 1'b1; ctr_val = L_GAP;  end
      ST_GAP:  if (phase_done) begin st_d = ST_LO;   ctr_load = 1'b1; ctr_val = L_LO;   end
      ST_LO:   if (phase_done) begin st_d = ST_WAIT; ctr_load = 1'b1; ctr_val = L_WAIT; end
      ST_WAIT: if (phase_done) begin st_d = ST_STRB; ctr_load = 1'b1; ctr_val = L_STRB; end
      ST_STRB: if (phase_done) begin st_d = ST_REST; ctr_load = 1'b1; ctr_val = L_REST; end
      ST_REST: begin
        if (finish) st_d = ST_IDLE;
        else if (readdr) begin st_d = ST_HI; ctr_load = 1'b1; ctr_val = L_HI; end
        else if (phase_done) begin st_d = ST_STRB; ctr_load = 1'b1; ctr_val = L_STRB; end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      rem_q      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      st_q       <= st_d;
      word_valid <= sample;
      if (accept)      rem_q <= req_len;
      else if (sample) rem_q <= rem_q - 1'b1;
      if (sample)      word_data <= rom_ad_i;
    end
  end

  assign busy         = (st_q != ST_IDLE);
  assign rom_sel_n    = (st_q == ST_IDLE);
  assign rom_lat_hi   = (st_q == ST_HI);
  assign rom_lat_lo   = (st_q == ST_LO);
  assign rom_strobe_n = (st_q != ST_STRB);
  assign rom_ad_oe    = (st_q == ST_HI) || (st_q == ST_GAP) || (st_q == ST_LO);
  assign rom_ad_o     = ((st_q == ST_HI) || (st_q == ST_GAP)) ? hi_word : lo_word;

  // ---------------- assertion support ----------------
  logic               strb_q, lath_q, latl_q, hi_done_q;
  logic [SINCE_W-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b1; lath_q <= 1'b0; latl_q <= 1'b0; hi_done_q <= 1'b0; since_q <= '1;
    end else begin
      strb_q <= rom_strobe_n;
      lath_q <= rom_lat_hi;
      latl_q <= rom_lat_lo;
      if (lath_q && !rom_lat_hi)      hi_done_q <= 1'b1;
      else if (latl_q && !rom_lat_lo) hi_done_q <= 1'b0;
      if (strb_q && !rom_strobe_n)    since_q <= '0;
      else if (since_q != '1)         since_q <= since_q + 1'b1;
    end
  end

  p_lat_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_lat_hi && rom_lat_lo));
  p_hi_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_lat_lo) |-> hi_done_q);
  p_hi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_lat_hi && lath_q) |-> ($stable(rom_ad_o) && rom_ad_oe));
  p_lo_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_lat_lo && latl_q) |-> ($stable(rom_ad_o) && rom_ad_oe));
  p_bus_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_strobe_n |-> !rom_ad_oe);
  p_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_strobe_n) |-> (since_q >= SINCE_W'(P_CYC - 1)));
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
endmodule

// File: tb/test_mrom_burst_rd.sv
`timescale 1ns/1ps
module test_mrom_burst_rd;
  localparam int CLK_NS = 5;
  localparam int T_AS = 30, T_CES = 50, T_ALES = 70, T_ALED = 70;
  localparam int T_LAT = 950, T_CYC = 200, T_ACC = 150, T_RDH = 40;
  localparam logic [15:0] POISON = 16'hDEAD;

  function automatic int clks(input int t);
    int n = 1;
    while (n * CLK_NS < t) n++;
    return n;
  endfunction

  localparam int E_HI   = clks((T_CES > T_AS) ? T_CES : T_AS);
  localparam int E_GAP  = clks(T_ALED);
  localparam int E_LO   = clks((T_ALES > T_AS) ? T_ALES : T_AS);
  localparam int E_WAIT = clks(T_LAT);
  localparam int E_STRB = clks(T_ACC);
  localparam int E_REST = ((clks(T_CYC) - E_STRB) > clks(T_RDH)) ? (clks(T_CYC) - E_STRB) : clks(T_RDH);

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic busy, word_valid, rom_sel_n, rom_lat_hi, rom_lat_lo, rom_strobe_n, rom_ad_oe;
  logic [15:0] word_data, rom_ad_o;
  logic [15:0] rom_ad_i = '0;

  always #2.5 clk = ~clk;

  mrom_burst_rd i_mrom_burst_rd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .word_data(word_data), .word_valid(word_valid),
    .rom_sel_n(rom_sel_n), .rom_lat_hi(rom_lat_hi), .rom_lat_lo(rom_lat_lo),
    .rom_strobe_n(rom_strobe_n), .rom_ad_oe(rom_ad_oe), .rom_ad_o(rom_ad_o), .rom_ad_i(rom_ad_i)
  );

  int n_checks = 0, n_errs = 0;

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rom_word(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], a[21:12]} ^ 16'h5A3C;
  endfunction

  function automatic int dur(input realtime t);
    return int'($realtime - t);
  endfunction

  // ---------------- memory model and monitors ----------------
  bit mon_en = 0;
  logic [15:0] m_hi = '0;
  logic [21:0] m_ptr = '0;
  realtime t_sel_fall = 0, t_ad_chg = 0, t_hi_rise = 0, t_hi_fall = 0;
  realtime t_lo_rise = 0, t_lo_fall = 0, t_sf = 0, t_sr = 0;
  bit hi_seen = 0, after_lo = 0, after_rise = 0;
  int n_hi, n_lo, n_got, e_order, e_hi_len, e_gap, e_lo_len, e_setup, e_sel;
  int e_lat, e_low, e_rest, e_cyc, e_bus;
  logic [15:0] hi_log [8];
  logic [15:0] lo_log [8];
  logic [15:0] got [32];

  always @(rom_ad_o) t_ad_chg = $realtime;
  always @(negedge rom_sel_n) t_sel_fall = $realtime;
  always @(posedge rom_lat_hi) t_hi_rise = $realtime;

  always @(negedge rom_lat_hi) if (mon_en) begin
    if (dur(t_hi_rise) != E_HI * CLK_NS) e_hi_len++;
    if (dur(t_ad_chg) < T_AS || !rom_ad_oe) e_setup++;
    if (rom_sel_n || dur(t_sel_fall) < T_CES) e_sel++;
    if (n_hi < 8) hi_log[n_hi] = rom_ad_o;
    n_hi++;
    m_hi = rom_ad_o;
    hi_seen = 1;
    t_hi_fall = $realtime;
  end

  always @(posedge rom_lat_lo) if (mon_en) begin
    t_lo_rise = $realtime;
    if (!hi_seen) e_order++;
    if (dur(t_hi_fall) != E_GAP * CLK_NS) e_gap++;
  end

  always @(negedge rom_lat_lo) if (mon_en) begin
    if (dur(t_lo_rise) != E_LO * CLK_NS) e_lo_len++;
    if (dur(t_ad_chg) < T_AS) e_setup++;
    if (n_lo < 8) lo_log[n_lo] = rom_ad_o;
    n_lo++;
    m_ptr = {m_hi[6:0], rom_ad_o[15:1]};
    hi_seen = 0; after_lo = 1; after_rise = 0;
    t_lo_fall = $realtime;
  end

  always @(negedge rom_strobe_n) if (mon_en) begin
    if (after_lo && dur(t_lo_fall) != E_WAIT * CLK_NS) e_lat++;
    if (after_rise && dur(t_sr) != E_REST * CLK_NS) e_rest++;
    if (after_rise && dur(t_sf) < T_CYC) e_cyc++;
    after_lo = 0;
    t_sf = $realtime;
  end

  always @(posedge rom_strobe_n) if (mon_en) begin
    if (dur(t_sf) != E_STRB * CLK_NS) e_low++;
    t_sr = $realtime;
    after_rise = 1;
  end

  // Data drive: poison at the strobe fall, valid word just before the access time ends.
  always @(negedge rom_strobe_n) if (mon_en) begin
    logic [21:0] cur;
    cur = m_ptr;
    m_ptr[7:0] = m_ptr[7:0] + 8'd1;
    rom_ad_i = POISON;
    #(T_ACC - 1);
    if (!rom_strobe_n) rom_ad_i = rom_word(cur);
  end

  always @(negedge clk) if (mon_en) begin
    if (!rom_strobe_n && rom_ad_oe) e_bus++;
    if ((rom_lat_hi || rom_lat_lo) && !rom_ad_oe) e_bus++;
    if (word_valid) begin
      if (n_got < 32) got[n_got] = word_data;
      n_got++;
    end
  end

  // ---------------- helpers ----------------
  task automatic clear_mon();
    n_hi = 0; n_lo = 0; n_got = 0; e_order = 0; e_hi_len = 0; e_gap = 0; e_lo_len = 0;
    e_setup = 0; e_sel = 0; e_lat = 0; e_low = 0; e_rest = 0; e_cyc = 0; e_bus = 0;
    hi_seen = 0; after_lo = 0; after_rise = 0;
  endtask

  task automatic send(input logic [21:0] a, input logic [7:0] len);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 5000) begin @(negedge clk); k++; end
    check_eq("R10", "burst finished in time", busy, 0);
  endtask

  task automatic check_burst(input logic [21:0] a, input int len);
    int pulses;
    logic [21:0] a2;
    pulses = 1 + ((int'(a[7:0]) + len - 1) / 256);
    a2 = a + 22'(256 - int'(a[7:0]));
    check_eq("R7", "word count", n_got, len);
    for (int i = 0; i < len && i < 32; i++)
      check_eq("R7", $sformatf("word %0d data", i), got[i], rom_word(a + 22'(i)));
    check_eq("R8", "upper latch pulses", n_hi, pulses);
    check_eq("R8", "lower latch pulses", n_lo, pulses);
    check_eq("R2", "first upper word", hi_log[0], {9'b0, a[21:15]});
    check_eq("R2", "first lower word", lo_log[0], {a[14:0], 1'b0});
    if (pulses > 1) begin
      check_eq("R8", "re-address upper word", hi_log[1], {9'b0, a2[21:15]});
      check_eq("R8", "re-address lower word", lo_log[1], {a2[14:0], 1'b0});
    end
    check_eq("R3", "latch order errors", e_order, 0);
    check_eq("R4", "upper latch width errors", e_hi_len, 0);
    check_eq("R4", "latch gap errors", e_gap, 0);
    check_eq("R4", "lower latch width errors", e_lo_len, 0);
    check_eq("R4", "address setup errors", e_setup + e_sel, 0);
    check_eq("R5", "first-read latency errors", e_lat, 0);
    check_eq("R5", "bus contention errors", e_bus, 0);
    check_eq("R6", "strobe low width errors", e_low, 0);
    check_eq("R6", "strobe high width errors", e_rest + e_cyc, 0);
    check_eq("R10", "select released", rom_sel_n, 1);
    check_eq("R10", "bus released", rom_ad_oe, 0);
  endtask

  task automatic run_burst(input logic [21:0] a, input int len);
    clear_mon();
    send(a, 8'(len));
    wait_idle();
    repeat (3) @(negedge clk);
    check_burst(a, len);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    check_eq("R1", "select idle", rom_sel_n, 1);
    check_eq("R1", "upper latch idle", rom_lat_hi, 0);
    check_eq("R1", "lower latch idle", rom_lat_lo, 0);
    check_eq("R1", "strobe idle", rom_strobe_n, 1);
    check_eq("R1", "bus enable idle", rom_ad_oe, 0);
    check_eq("R1", "busy idle", busy, 0);
    check_eq("R1", "valid idle", word_valid, 0);
  endtask

  task automatic t_basic();        run_burst(22'h012345, 4); endtask
  task automatic t_single();       run_burst(22'h2A0010, 1); endtask
  task automatic t_page_cross();   run_burst(22'h3ABCFD, 6); endtask
  task automatic t_top_wrap();     run_burst(22'h3FFFFE, 3); endtask

  // Burst ends on the last word of a page; a request arrives with the final valid pulse.
  task automatic t_page_end_busy_req();
    int seen = 0, k = 0;
    bit busy_again = 0;
    clear_mon();
    send(22'h0001FC, 8'd4);
    while (seen < 4 && k < 5000) begin
      @(negedge clk); k++;
      if (word_valid) seen++;
    end
    check_eq("R9", "busy at last word", busy, 1);
    req_valid = 1'b1; req_addr = 22'h000000; req_len = 8'd2;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (busy) busy_again = 1;
    end
    check_eq("R9", "request during busy started nothing", busy_again, 0);
    check_burst(22'h0001FC, 4);
  endtask

  task automatic t_zero_len();
    bit went_busy = 0;
    clear_mon();
    send(22'h155555, 8'd0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy || !rom_sel_n) went_busy = 1;
    end
    check_eq("R9", "zero length stays idle", went_busy, 0);
    check_eq("R9", "zero length latch pulses", n_hi + n_lo, 0);
    check_eq("R9", "zero length words", n_got, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    mon_en = 1;
    t_basic();
    t_single();
    t_page_cross();
    t_page_end_busy_req();
    t_zero_len();
    t_top_wrap();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    #(150000 * CLK_NS);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule